// File: doc/BRIEF.md
# Serial Memory Bus Sequencer

This block turns a processor's transaction request into the long train of bus cycles that a single-data-bit serial memory needs. The memory sits on an ordinary chip-enable / output-enable / write-enable strobe set. Every bit of address and data crosses one data wire, one bus cycle per bit. A request asks either to read 1 to 8 bytes starting at an address, or to write 1 to 8 bytes inside one aligned 8-byte page. The sequencer accepts the request, frames it, shifts it out bit by bit and returns a single response pulse that carries the read bytes or an error flag.

Each accepted transaction begins with a three-cycle sequence that brings the memory to a known state. A 16-bit address frame follows. The data cycles come next. A write then sends a three-cycle commit sequence and repeats read cycles until the memory reports that its internal programming is done. Bus timing comes from nanosecond minimums and the system clock period, all given as parameters. Each bus cycle has three parts in this order: a setup interval with chip enable high, an active interval with chip enable and one strobe low, and a short hold interval.

Top module: `serial_mem_sequencer`

## Requirements
- R1: After reset the block is idle: reqReady is 1, busCeN, busOeN and busWeN are 1, busDoe is 0 and rspValid is 0.
- R2: Every accepted request starts with the bus cycles read, write of bit 0, read.
- R3: After that sequence come 16 write cycles carrying the address frame, most significant bit first. The 7 bits above the 9-bit address are sent as 0.
- R4: A read of N bytes (1..8) then issues 8·N read cycles. Each byte arrives most significant bit first. Byte k of the transfer is returned in rspRdData[8k+7:8k].
- R5: A write of N bytes (1..8) issues 8·N write cycles. Byte k is taken from reqWrData[8k+7:8k] and sent most significant bit first. The write ends with the cycles read, write of bit 1, read.
- R6: After the commit sequence, the block issues read cycles until it samples a 1 on busDin. It then responds with rspError 0.
- R7: If POLL_LIMIT poll reads in a row all sample 0, the block stops polling and responds with rspError 1.
- R8: A request is rejected with rspError 1 and no bus cycle at all if its length is 0 or above 8, or if it is a write whose low 3 address bits plus its length exceed 8.
- R9: While busCeN is low, exactly one of busOeN and busWeN is low. busDoe is 0 whenever busOeN is low.
- R10: busCeN stays low for at least ACTIVE_CYC clocks per bus cycle and is high for at least SETUP_CYC clocks before each bus cycle. During a write cycle busDout does not change while busCeN is low.
- R11: reqReady is 1 only while idle, so one request is in flight at a time. rspValid is a one-clock pulse, after which the block is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle and able to take a request |
| reqWrite | input | 1 | 1 for a write, 0 for a read |
| reqAddr | input | ADDR_W | Byte address of the first byte |
| reqLen | input | LEN_W | Byte count, 1 to MAX_BYTES |
| reqWrData | input | 8·MAX_BYTES | Write bytes, byte k in bits 8k+7:8k |
| rspValid | output | 1 | One-clock response pulse |
| rspError | output | 1 | Request rejected or commit timed out |
| rspRdData | output | 8·MAX_BYTES | Read bytes, byte k in bits 8k+7:8k |
| busCeN | output | 1 | Memory chip enable, active low |
| busOeN | output | 1 | Memory output enable, active low |
| busWeN | output | 1 | Memory write enable, active low |
| busDout | output | 1 | Serial data driven toward the memory |
| busDoe | output | 1 | Drive enable for busDout |
| busDin | input | 1 | Serial data returned by the memory |

## Verification
Checked on every clock, whatever the traffic: strobe exclusivity and data-driver turn-off (R9), minimum chip-enable low and high lengths, data stability during a write strobe (R10), the single-pulse response, busy handshake, and the one-clock step from a malformed request to its error response. Only the bench scenarios can show the content and order of the bit stream. That covers the reset and commit framing, address bit order, byte packing of reads and writes, and poll termination on a 1 or after the poll limit. The bench also shows that a rejected request causes no bus cycle at all.

// File: rtl/busseq_pkg.sv
package busseq_pkg;

  typedef enum logic [1:0] {S_IDLE, S_BUS, S_RESP} seqState_e;
  typedef enum logic [1:0] {PH_SETUP, PH_ACTIVE, PH_HOLD} busPhase_e;
  typedef enum logic [2:0] {ST_RESET, ST_ADDR, ST_DATA, ST_COMMIT, ST_POLL} seqStep_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;     // latch address and write bytes
    logic loadBit;     // present the next outgoing bit
    logic selAddr;     // outgoing bit from address frame
    logic selData;     // outgoing bit from write bytes
    logic constBit;    // outgoing bit for framing cycles
    logic captureBit;  // take busDin into read byte
    logic byteEnd;     // captured bit completes a byte
  } dpCtl_t;

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int maxInt(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/busseq_datapath.sv
module busseq_datapath
  import busseq_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int FRAME_W   = 16,
  parameter int MAX_BYTES = 8,
  localparam int DATA_W   = MAX_BYTES * 8,
  localparam int BIDX_W   = $clog2(MAX_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWrData,
  input  logic              busDin,
  output logic              busDout,
  output logic [DATA_W-1:0] rspRdData
);

  logic [FRAME_W-1:0] addrShift;
  logic [DATA_W-1:0]  wrSeq;
  logic [DATA_W-1:0]  wrOrdered;
  logic [7:0]         rdByte;
  logic [7:0]         rdNext;
  logic [BIDX_W-1:0]  rdIdx;

  // byte 0 goes out first: place it at the top of the shift register
  for (genvar g = 0; g < MAX_BYTES; g++) begin : gOrder
    assign wrOrdered[DATA_W-1-8*g -: 8] = reqWrData[8*g +: 8];
  end

  assign rdNext = {rdByte[6:0], busDin};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrShift <= '0;
      wrSeq     <= '0;
      rdByte    <= '0;
      rdIdx     <= '0;
      rspRdData <= '0;
      busDout   <= 1'b0;
    end else begin
      if (ctl.loadReq) begin
        addrShift <= FRAME_W'(reqAddr);
        wrSeq     <= wrOrdered;
        rdByte    <= '0;
        rdIdx     <= '0;
        rspRdData <= '0;
      end
      if (ctl.loadBit) begin
        if (ctl.selAddr) begin
          busDout   <= addrShift[FRAME_W-1];
          addrShift <= {addrShift[FRAME_W-2:0], 1'b0};
        end else if (ctl.selData) begin
          busDout <= wrSeq[DATA_W-1];
          wrSeq   <= {wrSeq[DATA_W-2:0], 1'b0};
        end else begin
          busDout <= ctl.constBit;
        end
      end
      if (ctl.captureBit) begin
        rdByte <= rdNext;
        if (ctl.byteEnd) begin
          rspRdData[8*rdIdx +: 8] <= rdNext;
          rdIdx <= rdIdx + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/busseq_ctrl.sv
module busseq_ctrl
  import busseq_pkg::*;
#(
  parameter int SETUP_CYC  = 10,
  parameter int ACTIVE_CYC = 4,
  parameter int HOLD_CYC   = 1,
  parameter int FRAME_W    = 16,
  parameter int MAX_BYTES  = 8,
  parameter int POLL_LIMIT = 64,
  localparam int LEN_W     = $clog2(MAX_BYTES + 1),
  localparam int PAGE_W    = $clog2(MAX_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [PAGE_W-1:0] reqAddrLow,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic              busDin,
  output logic              reqReady,
  output logic              rspValid,
  output logic              rspError,
  output logic              busCeN,
  output logic              busOeN,
  output logic              busWeN,
  output logic              busDoe,
  output dpCtl_t            dpCtl
);

  localparam int IDX_W  = $clog2(maxInt(FRAME_W, MAX_BYTES * 8));
  localparam int PCNT_W = $clog2(maxInt(maxInt(SETUP_CYC, ACTIVE_CYC), HOLD_CYC) + 1);
  localparam int POLL_W = $clog2(POLL_LIMIT + 1);

  seqState_e         state;
  seqStep_e          step;
  busPhase_e         phase;
  logic [PCNT_W-1:0] phaseCnt;
  logic [PCNT_W-1:0] phaseEnd;
  logic [IDX_W-1:0]  idx;
  logic [POLL_W-1:0] pollCnt;
  logic [LEN_W-1:0]  lenReg;
  logic              isWrite;
  logic              errFlag;
  logic              pollHigh;

  logic              reqBad;
  logic              accept;
  logic              cycleRead;
  logic              phaseLast;
  logic              active;
  logic [LEN_W:0]    pageEnd;
  logic [IDX_W:0]    dataLast;

  always_comb begin
    pageEnd  = (LEN_W+1)'(reqAddrLow) + (LEN_W+1)'(reqLen);
    reqBad   = (reqLen == '0) || (reqLen > LEN_W'(MAX_BYTES)) ||
               (reqWrite && (pageEnd > (LEN_W+1)'(MAX_BYTES)));
    accept   = (state == S_IDLE) && reqValid;
    dataLast = (IDX_W+1)'({lenReg, 3'b000}) - 1'b1;
    case (phase)
      PH_SETUP:  phaseEnd = PCNT_W'(SETUP_CYC - 1);
      PH_ACTIVE: phaseEnd = PCNT_W'(ACTIVE_CYC - 1);
      default:   phaseEnd = PCNT_W'(HOLD_CYC - 1);
    endcase
    phaseLast = (phaseCnt == phaseEnd);
    case (step)
      ST_RESET:  cycleRead = (idx != IDX_W'(1));
      ST_ADDR:   cycleRead = 1'b0;
      ST_DATA:   cycleRead = !isWrite;
      ST_COMMIT: cycleRead = (idx != IDX_W'(1));
      default:   cycleRead = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      step     <= ST_RESET;
      phase    <= PH_SETUP;
      phaseCnt <= '0;
      idx      <= '0;
      pollCnt  <= '0;
      lenReg   <= '0;
      isWrite  <= 1'b0;
      errFlag  <= 1'b0;
      pollHigh <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (reqValid) begin
          lenReg  <= reqLen;
          isWrite <= reqWrite;
          errFlag <= reqBad;
          if (reqBad) begin
            state <= S_RESP;
          end else begin
            state    <= S_BUS;
            step     <= ST_RESET;
            phase    <= PH_SETUP;
            phaseCnt <= '0;
            idx      <= '0;
            pollCnt  <= '0;
            pollHigh <= 1'b0;
          end
        end
        S_BUS: begin
          if (!phaseLast) begin
            phaseCnt <= phaseCnt + 1'b1;
          end else begin
            phaseCnt <= '0;
            case (phase)
              PH_SETUP:  phase <= PH_ACTIVE;
              PH_ACTIVE: begin
                phase <= PH_HOLD;
                if (step == ST_POLL) pollHigh <= busDin;
              end
              default: begin
                phase <= PH_SETUP;
                idx   <= idx + 1'b1;
                case (step)
                  ST_RESET: if (idx == IDX_W'(2)) begin
                    step <= ST_ADDR;
                    idx  <= '0;
                  end
                  ST_ADDR: if (idx == IDX_W'(FRAME_W - 1)) begin
                    step <= ST_DATA;
                    idx  <= '0;
                  end
                  ST_DATA: if ({1'b0, idx} == dataLast) begin
                    idx <= '0;
                    if (isWrite) step <= ST_COMMIT;
                    else         state <= S_RESP;
                  end
                  ST_COMMIT: if (idx == IDX_W'(2)) begin
                    step <= ST_POLL;
                    idx  <= '0;
                  end
                  default: begin
                    idx <= '0;
                    if (pollHigh) begin
                      state <= S_RESP;
                    end else if (pollCnt == POLL_W'(POLL_LIMIT - 1)) begin
                      errFlag <= 1'b1;
                      state   <= S_RESP;
                    end else begin
                      pollCnt <= pollCnt + 1'b1;
                    end
                  end
                endcase
              end
            endcase
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign active   = (state == S_BUS) && (phase == PH_ACTIVE);
  assign busCeN   = !active;
  assign busOeN   = !(active && cycleRead);
  assign busWeN   = !(active && !cycleRead);
  assign busDoe   = (state == S_BUS) && !cycleRead;
  assign reqReady = (state == S_IDLE);
  assign rspValid = (state == S_RESP);
  assign rspError = errFlag;

  always_comb begin
    dpCtl            = '0;
    dpCtl.loadReq    = accept && !reqBad;
    dpCtl.loadBit    = (state == S_BUS) && (phase == PH_SETUP) &&
                       (phaseCnt == '0) && !cycleRead;
    dpCtl.selAddr    = (step == ST_ADDR);
    dpCtl.selData    = (step == ST_DATA);
    dpCtl.constBit   = (step == ST_COMMIT);
    dpCtl.captureBit = active && phaseLast && (step == ST_DATA) && !isWrite;
    dpCtl.byteEnd    = (idx[2:0] == 3'b111);
  end

  // run-length counters used only by the timing properties below
  logic [PCNT_W:0] lowRun;
  logic [PCNT_W:0] highRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowRun  <= '0;
      highRun <= '0;
    end else begin
      lowRun  <= busCeN ? '0 : ((&lowRun) ? lowRun : lowRun + 1'b1);
      highRun <= !busCeN ? '0 : ((&highRun) ? highRun : highRun + 1'b1);
    end
  end

  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rstN)
    !busCeN |-> (busOeN != busWeN));

  assert_no_drive_on_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    !busOeN |-> !busDoe);

  assert_ce_low_min_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busCeN) |-> (lowRun >= (PCNT_W+1)'(ACTIVE_CYC)));

  assert_ce_high_min_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busCeN) |-> (highRun >= (PCNT_W+1)'(SETUP_CYC)));

  assert_reject_resp_R8: assert property (@(posedge clk) disable iff (!rstN)
    (accept && reqBad) |=> (rspValid && rspError && busCeN));

  assert_rsp_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> (!rspValid && reqReady));

  assert_busy_after_accept_R11: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

endmodule

// File: rtl/serial_mem_sequencer.sv
module serial_mem_sequencer
  import busseq_pkg::*;
#(
  parameter int CLK_NS      = 20,
  parameter int CYCLE_NS    = 300,
  parameter int CE_LOW_NS   = 70,
  parameter int CE_HIGH_NS  = 70,
  parameter int STROBE_NS   = 30,
  parameter int RECOVERY_NS = 200,
  parameter int HOLD_NS     = 5,
  parameter int ADDR_W      = 9,
  parameter int FRAME_W     = 16,
  parameter int MAX_BYTES   = 8,
  parameter int POLL_LIMIT  = 64,
  localparam int LEN_W      = $clog2(MAX_BYTES + 1),
  localparam int DATA_W     = MAX_BYTES * 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [DATA_W-1:0] reqWrData,
  output logic              rspValid,
  output logic              rspError,
  output logic [DATA_W-1:0] rspRdData,
  output logic              busCeN,
  output logic              busOeN,
  output logic              busWeN,
  output logic              busDout,
  output logic              busDoe,
  input  logic              busDin
);

  localparam int PAGE_W     = $clog2(MAX_BYTES);
  localparam int ACTIVE_CYC = maxInt(ceilDiv(CE_LOW_NS, CLK_NS), ceilDiv(STROBE_NS, CLK_NS));
  localparam int HOLD_CYC   = maxInt(1, ceilDiv(HOLD_NS, CLK_NS));
  localparam int SETUP_CYC  = maxInt(1, maxInt(
      ceilDiv(maxInt(RECOVERY_NS, CE_HIGH_NS), CLK_NS) - HOLD_CYC,
      ceilDiv(CYCLE_NS, CLK_NS) - ACTIVE_CYC - HOLD_CYC));

  dpCtl_t dpCtl;

  busseq_ctrl #(
    .SETUP_CYC (SETUP_CYC),
    .ACTIVE_CYC(ACTIVE_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .FRAME_W   (FRAME_W),
    .MAX_BYTES (MAX_BYTES),
    .POLL_LIMIT(POLL_LIMIT)
  ) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqWrite  (reqWrite),
    .reqAddrLow(reqAddr[PAGE_W-1:0]),
    .reqLen    (reqLen),
    .busDin    (busDin),
    .reqReady  (reqReady),
    .rspValid  (rspValid),
    .rspError  (rspError),
    .busCeN    (busCeN),
    .busOeN    (busOeN),
    .busWeN    (busWeN),
    .busDoe    (busDoe),
    .dpCtl     (dpCtl)
  );

  busseq_datapath #(
    .ADDR_W   (ADDR_W),
    .FRAME_W  (FRAME_W),
    .MAX_BYTES(MAX_BYTES)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (dpCtl),
    .reqAddr  (reqAddr),
    .reqWrData(reqWrData),
    .busDin   (busDin),
    .busDout  (busDout),
    .rspRdData(rspRdData)
  );

  // data driven to the memory must not move while a write strobe is low
  assert_dout_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!busCeN && !$past(busCeN) && busDoe) |-> $stable(busDout));

endmodule

// File: tb/test_serial_mem_sequencer.sv
`timescale 1ns/1ps
module test_serial_mem_sequencer;

  localparam int CLK_NS     = 20;
  localparam int POLL_LIMIT = 16;
  localparam int MIN_LOW    = (70 + CLK_NS - 1) / CLK_NS;

  typedef struct {
    bit    rd;
    bit    val;
    bit    din;
    string tag;
  } busOp_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [8:0]  reqAddr = '0;
  logic [3:0]  reqLen = '0;
  logic [63:0] reqWrData = '0;
  logic        rspValid;
  logic        rspError;
  logic [63:0] rspRdData;
  logic        busCeN, busOeN, busWeN, busDout, busDoe;
  logic        busDin = 1'b1;

  int checks = 0;
  int errors = 0;
  busOp_t expQ[$];
  busOp_t cur;
  bit inLow = 1'b0;
  int lowCnt = 0;
  logic [7:0] mem [0:511];

  always #10 clk = ~clk;

  serial_mem_sequencer #(.CLK_NS(CLK_NS), .POLL_LIMIT(POLL_LIMIT)) i_serial_mem_sequencer (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqLen(reqLen), .reqWrData(reqWrData),
    .rspValid(rspValid), .rspError(rspError), .rspRdData(rspRdData),
    .busCeN(busCeN), .busOeN(busOeN), .busWeN(busWeN), .busDout(busDout),
    .busDoe(busDoe), .busDin(busDin)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic pushOp(input bit rd, input bit val, input bit din, input string tag);
    busOp_t op;
    op.rd = rd; op.val = val; op.din = din; op.tag = tag;
    expQ.push_back(op);
  endtask

  task automatic pushFront(input logic [8:0] addr);
    logic [15:0] frame;
    pushOp(1'b1, 1'b0, 1'b1, "R2");
    pushOp(1'b0, 1'b0, 1'b1, "R2");
    pushOp(1'b1, 1'b0, 1'b1, "R2");
    frame = {7'b0, addr};
    for (int i = 15; i >= 0; i--) pushOp(1'b0, frame[i], 1'b1, "R3");
  endtask

  // cycle-by-cycle bus monitor and memory-side responder
  always @(negedge clk) begin
    if (rstN) begin
      check(!(!busCeN && !busOeN && !busWeN) && !(!busOeN && busDoe), "R9",
            "strobe overlap", {busCeN, busOeN, busWeN, busDoe}, 4'b0101);
      if (!busCeN && !inLow) begin
        inLow  = 1'b1;
        lowCnt = 1;
        if (expQ.size() == 0) begin
          check(1'b0, "R8", "unexpected bus cycle", 1, 0);
          cur.rd = 1'b1; cur.val = 1'b0; cur.din = 1'b1; cur.tag = "R8";
        end else begin
          cur = expQ.pop_front();
          if (cur.rd)
            check(!busOeN && busWeN, cur.tag, "read cycle strobes",
                  {busOeN, busWeN}, 2'b01);
          else
            check(busOeN && !busWeN && busDoe && (busDout == cur.val), cur.tag,
                  "write cycle strobes/bit", {busOeN, busWeN, busDoe, busDout},
                  {1'b1, 1'b0, 1'b1, cur.val});
        end
        busDin = cur.din;
      end else if (!busCeN) begin
        lowCnt++;
        if (!cur.rd) check(busDout == cur.val, "R10", "dout moved in strobe",
                           busDout, cur.val);
      end else if (inLow) begin
        inLow = 1'b0;
        check(lowCnt >= MIN_LOW, "R10", "ce low length", 64'(lowCnt), 64'(MIN_LOW));
      end
    end
  end

  task automatic runReq(input bit wr, input logic [8:0] addr, input int len,
                        input logic [63:0] wdata, input bit expErr,
                        input logic [63:0] expData, input string tag);
    int n;
    @(negedge clk);
    check(reqReady, "R11", "ready before request", reqReady, 1);
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr; reqLen = 4'(len); reqWrData = wdata;
    @(negedge clk);
    reqValid = 1'b0;
    check(!reqReady, "R11", "busy after accept", reqReady, 0);
    n = 0;
    while (!rspValid && n < 20000) begin
      @(negedge clk);
      n++;
    end
    check(rspValid, tag, "response arrived", rspValid, 1);
    check(rspError == expErr, tag, "response error", rspError, expErr);
    check(rspRdData == expData, tag, "response data", rspRdData, expData);
    check(expQ.size() == 0, tag, "bus cycles left", 64'(expQ.size()), 0);
    @(negedge clk);
    check(!rspValid && reqReady, "R11", "single response pulse",
          {rspValid, reqReady}, 2'b01);
  endtask

  task automatic doRead(input logic [8:0] addr, input int len);
    logic [63:0] exp = '0;
    pushFront(addr);
    for (int b = 0; b < len; b++) begin
      logic [7:0] v = mem[(addr + b) % 512];
      exp[8*b +: 8] = v;
      for (int i = 7; i >= 0; i--) pushOp(1'b1, 1'b0, v[i], "R4");
    end
    runReq(1'b0, addr, len, '0, 1'b0, exp, "R4");
  endtask

  task automatic doWrite(input logic [8:0] addr, input int len, input logic [63:0] data,
                         input int busyPolls, input bit hang);
    pushFront(addr);
    for (int b = 0; b < len; b++)
      for (int i = 7; i >= 0; i--) pushOp(1'b0, data[8*b + i], 1'b1, "R5");
    pushOp(1'b1, 1'b0, 1'b1, "R5");
    pushOp(1'b0, 1'b1, 1'b1, "R5");
    pushOp(1'b1, 1'b0, 1'b1, "R5");
    if (hang) begin
      for (int p = 0; p < POLL_LIMIT; p++) pushOp(1'b1, 1'b0, 1'b0, "R7");
      runReq(1'b1, addr, len, data, 1'b1, '0, "R7");
    end else begin
      for (int p = 0; p < busyPolls; p++) pushOp(1'b1, 1'b0, 1'b0, "R6");
      pushOp(1'b1, 1'b0, 1'b1, "R6");
      runReq(1'b1, addr, len, data, 1'b0, '0, "R6");
    end
  endtask

  task automatic doReject(input bit wr, input logic [8:0] addr, input int len);
    runReq(wr, addr, len, 64'h1122334455667788, 1'b1, '0, "R8");
    repeat (40) @(negedge clk);
    check(busCeN && !inLow, "R8", "bus idle after reject", busCeN, 1);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 3));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check({reqReady, busCeN, busOeN, busWeN, busDoe, rspValid} == 6'b111100, "R1",
          "idle after reset", {reqReady, busCeN, busOeN, busWeN, busDoe, rspValid}, 6'b111100);
    doRead(9'h005, 1);
    doRead(9'h1FC, 8);
    doWrite(9'h0A8, 8, 64'hF00D_BEEF_1234_A55A, 3, 1'b0);
    doWrite(9'h0F5, 3, 64'h0000_0000_00C3_7E81, 0, 1'b0);
    doReject(1'b1, 9'h0F6, 3);
    doReject(1'b0, 9'h010, 0);
    doReject(1'b1, 9'h010, 9);
    doWrite(9'h130, 2, 64'h0000_0000_0000_5AA5, 0, 1'b1);
    doRead(9'h133, 5);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule